// File: doc/BRIEF.md
# Per-Load Stride Prefetcher

This block watches the stream of load instructions retired or issued by a core. Each observed load arrives as a program counter and a cache-block address, with the address counted in whole blocks. A small direct-mapped table, indexed by low PC bits and guarded by a partial PC tag, remembers for each load the block it touched last, the step between its last two blocks, and a two-bit saturating confidence count. Once a load has repeated the same non-zero step often enough, the block requests blocks further down that load's path, so the data is on its way before the load reaches it.

A trigger does not produce one request. It produces a short burst. The first request is `DIST` steps beyond the current block and the following ones continue one step apart, `DEGREE` requests in total. Triggers wait in a small queue ahead of an issue state machine. That machine has two states. In `S_IDLE` it waits, and it takes the transition *pop* to `S_ISSUE` when the queue holds a trigger. In `S_ISSUE` it presents one address at a time on a valid/ready port. On each accepted address it either takes the transition *step*, staying in `S_ISSUE` with the next address, or the transition *done*, returning to `S_IDLE` after the last request of the burst. Requests carry addresses only. No data is stored.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, `pf_valid` is 0 and every table entry is empty, so the first load seen at any index causes no request.
- R2: A load selects entry `ld_pc[IDX_W-1:0]` and compares tag `ld_pc[IDX_W+TAG_W-1:IDX_W]`. If the entry is empty or the tag differs, the entry is rewritten with that tag, the load's address, a step of 0 and a confidence of 0, and no request results.
- R3: On a tag hit, the new step is `ld_addr` minus the stored address, modulo 2^ADDR_W. Both the address and the step are stored in the entry.
- R4: On a tag hit, confidence goes up by 1 (stopping at 3) when the new step equals the stored step, and down by 1 (stopping at 0) otherwise.
- R5: A tag hit triggers when the new step equals the stored step, the updated confidence is 2 or more, and the step is non-zero.
- R6: A trigger at address A with step S yields exactly `DEGREE` requests, in order, at A + (DIST+k)*S modulo 2^ADDR_W for k = 0 .. DEGREE-1.
- R7: A step of zero never triggers, however high the confidence climbs.
- R8: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` does not change. A request is consumed on a clock edge where both are 1.
- R9: Up to `QDEPTH` triggers wait in the queue, in addition to the one being issued. A trigger that arrives while the queue is full is dropped completely and produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is observed this cycle |
| ld_pc | input | PC_W | Program counter of the observed load |
| ld_addr | input | ADDR_W | Block address the load touched |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Downstream accepts the offered request |
| pf_addr | output | ADDR_W | Block address to prefetch |

## Verification
The bench builds the block with a 16-bit address, a 4-entry table with a 3-bit tag, a distance of 2, a degree of 2 and a two-deep queue. The table is small enough that aliasing PCs and entry replacement occur after a few loads. The queue is shallow enough that holding `pf_ready` low fills it after three triggers, so the drop case is reached quickly. The bench sweeps positive, negative, wrapping and zero steps, runs interleaved streams, and runs a step pattern that breaks and recovers. It predicts every request address with plain arithmetic from these settings.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
    localparam int CONF_W    = 2;
    localparam int CONF_MAX  = 3;
    localparam int CONF_FIRE = 2;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } issue_state_e;
endpackage

// File: rtl/stride_table.sv
module stride_table
    import stride_pf_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DIST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              trig,
    output logic [ADDR_W-1:0] trig_first,
    output logic [ADDR_W-1:0] trig_stride
);
    localparam int ENTRIES = 1 << IDX_W;

    logic              vld_q    [ENTRIES];
    logic [TAG_W-1:0]  tag_q    [ENTRIES];
    logic [ADDR_W-1:0] last_q   [ENTRIES];
    logic [ADDR_W-1:0] stride_q [ENTRIES];
    logic [CONF_W-1:0] conf_q   [ENTRIES];

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              hit;
    logic              same;
    logic [ADDR_W-1:0] new_stride;
    logic [CONF_W-1:0] conf_nxt;

    always_comb begin
        idx        = ld_pc[IDX_W-1:0];
        tag        = ld_pc[IDX_W+TAG_W-1:IDX_W];
        hit        = vld_q[idx] && (tag_q[idx] == tag);
        new_stride = ld_addr - last_q[idx];
        same       = (new_stride == stride_q[idx]);
        if (same)
            conf_nxt = (conf_q[idx] == CONF_W'(CONF_MAX)) ? conf_q[idx] : conf_q[idx] + 1'b1;
        else
            conf_nxt = (conf_q[idx] == '0) ? conf_q[idx] : conf_q[idx] - 1'b1;
        trig        = ld_valid && hit && same && (conf_nxt >= CONF_W'(CONF_FIRE))
                      && (new_stride != '0);
        trig_first  = ld_addr + ADDR_W'(DIST) * new_stride;
        trig_stride = new_stride;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld_q[i]    <= 1'b0;
                tag_q[i]    <= '0;
                last_q[i]   <= '0;
                stride_q[i] <= '0;
                conf_q[i]   <= '0;
            end
        end else if (ld_valid) begin
            last_q[idx] <= ld_addr;
            if (!hit) begin
                vld_q[idx]    <= 1'b1;
                tag_q[idx]    <= tag;
                stride_q[idx] <= '0;
                conf_q[idx]   <= '0;
            end else begin
                stride_q[idx] <= new_stride;
                conf_q[idx]   <= conf_nxt;
            end
        end
    end

    // R2: a freshly written entry starts with zero confidence
    p_alloc_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && !hit |=> conf_q[$past(idx)] == '0);
endmodule

// File: rtl/pf_queue.sv
module pf_queue #(
    parameter int W     = 64,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= push_data;
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop)
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push && full |=> cnt_q <= $past(cnt_q));
    // R7: no trigger with a zero step ever reaches the queue
    p_nonzero_stride_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> push_data[W/2-1:0] != '0);
endmodule

// File: rtl/pf_issue.sv
module pf_issue
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEGREE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic [ADDR_W-1:0] q_first,
    input  logic [ADDR_W-1:0] q_stride,
    output logic              q_pop,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int CNT_W = $clog2(DEGREE + 1);

    issue_state_e      state_q, state_d;
    logic [ADDR_W-1:0] cur_q, step_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_one;

    assign last_one = (cnt_q == CNT_W'(DEGREE - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        q_pop    = 1'b0;
        pf_valid = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (!q_empty) begin
                    q_pop   = 1'b1;
                    state_d = S_ISSUE;
                end
            end
            S_ISSUE: begin
                pf_valid = 1'b1;
                if (pf_ready && last_one) state_d = S_IDLE;
            end
        endcase
    end

    assign pf_addr = cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            step_q <= '0;
            cnt_q  <= '0;
        end else if (q_pop) begin
            cur_q  <= q_first;
            step_q <= q_stride;
            cnt_q  <= '0;
        end else if (pf_valid && pf_ready && !last_one) begin
            cur_q <= cur_q + step_q;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));
    p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> cnt_q < CNT_W'(DEGREE));
    // R6: consecutive requests of one burst are one step apart
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready && !last_one |=> pf_addr == $past(pf_addr) + step_q);
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DIST   = 4,
    parameter int DEGREE = 2,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int QW = 2 * ADDR_W;

    logic              trig;
    logic [ADDR_W-1:0] trig_first, trig_stride;
    logic [QW-1:0]     q_head;
    logic              q_empty, q_full, q_pop;

    stride_table #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DIST(DIST)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .trig(trig), .trig_first(trig_first),
        .trig_stride(trig_stride)
    );

    pf_queue #(.W(QW), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(trig),
        .push_data({trig_first, trig_stride}), .pop(q_pop),
        .head(q_head), .empty(q_empty), .full(q_full)
    );

    pf_issue #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_issue (
        .clk(clk), .rst_n(rst_n), .q_empty(q_empty),
        .q_first(q_head[QW-1:ADDR_W]), .q_stride(q_head[ADDR_W-1:0]),
        .q_pop(q_pop), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    // R1: no request is offered in the first cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);
endmodule

// File: tb/stride_prefetcher_bench.sv
module stride_prefetcher_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 12, ADDR_W = 16, IDX_W = 2, TAG_W = 3;
    localparam int DIST = 2, DEGREE = 2, QDEPTH = 2;
    localparam int ENT = 1 << IDX_W;

    logic clk = 0, rst_n = 0, ld_valid = 0, pf_ready = 1;
    logic [PC_W-1:0] ld_pc = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic pf_valid;
    logic [ADDR_W-1:0] pf_addr;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stride_prefetcher #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .DIST(DIST), .DEGREE(DEGREE), .QDEPTH(QDEPTH)
    ) u_stride_prefetcher (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_addr(pf_addr)
    );

    // expectation model, built from the requirements
    logic              mv [ENT];
    logic [TAG_W-1:0]  mt [ENT];
    logic [ADDR_W-1:0] ml [ENT];
    logic [ADDR_W-1:0] ms [ENT];
    int                mc [ENT];
    logic [ADDR_W-1:0] expq [1024];
    int eh = 0, et = 0;
    bit hold = 0;
    int accepted = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R6 address order, R8 handshake; unexpected requests break R2/R5/R7/R9
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready) begin
            if (eh == et)
                check(0, "R5 unexpected request", int'(pf_addr), -1);
            else begin
                check(pf_addr == expq[eh], "R6 request address", int'(pf_addr), int'(expq[eh]));
                eh++;
            end
        end
    end

    task automatic load(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a);
        int i;
        logic [TAG_W-1:0] tg;
        logic [ADDR_W-1:0] ns;
        bit same;
        i  = int'(pc[IDX_W-1:0]);
        tg = pc[IDX_W+TAG_W-1:IDX_W];
        if (!mv[i] || mt[i] != tg) begin          // R2 replacement
            mv[i] = 1; mt[i] = tg; ms[i] = '0; mc[i] = 0;
        end else begin
            ns   = a - ml[i];                     // R3
            same = (ns == ms[i]);
            if (same) mc[i] = (mc[i] == 3) ? 3 : mc[i] + 1;   // R4
            else      mc[i] = (mc[i] == 0) ? 0 : mc[i] - 1;
            if (same && mc[i] >= 2 && ns != 0) begin          // R5, R7
                if (!hold || accepted < 1 + QDEPTH) begin     // R9
                    for (int k = 0; k < DEGREE; k++) begin
                        expq[et] = a + ADDR_W'(DIST + k) * ns;
                        et++;
                    end
                end
                if (hold) accepted++;
            end
            ms[i] = ns;
        end
        ml[i] = a;
        @(posedge clk); #1;
        ld_valid = 1; ld_pc = pc; ld_addr = a;
        @(posedge clk); #1;
        ld_valid = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic stream(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] base,
                          input int step, input int n);
        for (int j = 0; j < n; j++) load(pc, base + ADDR_W'(step * j));
    endtask

    task automatic drain_check(input string req);
        repeat (20) @(posedge clk);
        check(eh == et, req, eh, et);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENT; i++) begin mv[i] = 0; mt[i] = '0; ml[i] = '0; ms[i] = '0; mc[i] = 0; end
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        check(pf_valid == 0, "R1 idle after reset", int'(pf_valid), 0);

        // R1/R2: the first load at every index requests nothing
        for (int i = 0; i < ENT; i++) load(PC_W'(i), 16'h0100);
        drain_check("R1 first touch silent");

        // R3/R4/R5/R6: sweep of steps on fresh PCs, including negative and wrap
        begin
            int steps[7] = '{1, -1, 3, -4, 7, 2, -9};
            for (int s = 0; s < 7; s++) begin
                stream(PC_W'(s * 5 + 8), ADDR_W'(16'h8000 + s * 64), steps[s], 7);
                drain_check("R6 sweep burst count");
            end
        end
        stream(12'h011, 16'h0002, -1, 7);       // R6 wraps below zero
        stream(12'h012, 16'hFFFC, 2, 7);        // R6 wraps above top
        drain_check("R6 wrap burst count");

        // R7: zero step with full confidence never requests
        stream(12'h021, 16'h4000, 0, 8);
        drain_check("R7 zero step silent");

        // R2: aliasing PCs on one index with different tags replace each other
        for (int j = 0; j < 6; j++) begin
            load(12'h003, 16'h1000 + ADDR_W'(j * 4));
            load(12'h00B, 16'h2000 + ADDR_W'(j * 4));
        end
        drain_check("R2 aliasing silent");

        // interleaved streams on separate indexes
        for (int j = 0; j < 6; j++) begin
            load(12'h040, 16'h3000 + ADDR_W'(j * 3));
            load(12'h041, 16'h5000 - ADDR_W'(j * 5));
        end
        drain_check("R5 interleaved streams");

        // R4: step breaks and recovers; confidence decays and climbs again
        begin
            int pat[12] = '{4, 4, 4, 4, 9, 4, 4, 9, 1, 9, 9, 9};
            logic [ADDR_W-1:0] a;
            a = 16'h6000;
            load(12'h052, a);
            for (int j = 0; j < 12; j++) begin
                a = a + ADDR_W'(pat[j]);
                load(12'h052, a);
            end
        end
        drain_check("R4 confidence walk");

        // R8/R9: downstream stalls, queue fills, later triggers are dropped
        @(posedge clk); #1; pf_ready = 0;
        hold = 1; accepted = 0;
        stream(12'h063, 16'h7000, 6, 9);
        repeat (5) @(posedge clk);
        @(negedge clk);
        begin
            logic [ADDR_W-1:0] held;
            held = pf_addr;
            check(pf_valid == 1, "R8 valid held while stalled", int'(pf_valid), 1);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(pf_valid == 1 && pf_addr == held, "R8 address held", int'(pf_addr), int'(held));
        end
        @(posedge clk); #1; pf_ready = 1;
        hold = 0;
        repeat (40) @(posedge clk);
        check(eh == et, "R9 only queued triggers delivered", eh, et);
        check(accepted == 6, "R9 trigger count in stall test", accepted, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule